// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial bit stream into parallel characters. It runs from a receive clock that is 1, 16 or 64 times the bit rate, and the factor can be changed at run time through a configuration input. A falling level on the line is only a candidate start bit. At the x16 and x64 factors the receiver samples the line again half a bit later and accepts the start only if the line is still low. It then samples each data bit at its centre, least significant bit first. When parity is enabled it checks the parity bit, and it then samples the first stop bit.

A finished character is placed in a holding register and a ready flag is raised for the host. The host clears the flag with a one-cycle read strobe. Parity, framing and overrun conditions are kept as sticky flags. They clear only when the error-clear input is pulsed. The serial input first passes through a two-stage synchronizer, so every sampling decision sees the line two clock cycles late. All configuration inputs are expected to stay stable while a character is being received.

Top module: `serial_rx_os`

## Requirements
- R1: `cfg_factor` selects the clock-per-bit factor: 2'b00 gives x1, 2'b01 gives x16, and 2'b10 or 2'b11 give x64. After a start is accepted, each later bit is sampled one full bit time (factor cycles) after the previous sample.
- R2: At x16 and x64 a low line is re-sampled half a bit time later. If it is high at that point, the receiver goes back to idle and no character is produced.
- R3: When the stop bit has been sampled, `rx_data` holds the character, right-justified, least significant bit received first, with unused upper bits zero. `rx_ready` is 1 from the next cycle on. After reset `rx_ready`, all error flags and `rx_data` are 0.
- R4: At x1 there is no half-bit check. The clock edge that sees the start bit is followed by one bit sample on each later edge.
- R5: `cfg_len` sets the data length to 5 + `cfg_len` bits (0 gives 5 bits, 3 gives 8 bits).
- R6: A one-cycle `rd_stb` clears `rx_ready`. If a character completes in the same cycle, `rx_ready` stays 1.
- R7: With `cfg_par_en` = 1, one parity bit follows the data. With `cfg_par_odd` = 0 the data bits plus the parity bit hold an even number of ones, and with 1 an odd number. A mismatch sets `parity_err` when the character completes.
- R8: A low level sampled at the centre of the stop bit sets `frame_err` when the character completes.
- R9: If a character completes while `rx_ready` is still 1 and no read happens that cycle, `overrun_err` is set and the new character replaces the old one.
- R10: The error flags stay set through reads and later good characters. They clear on an `err_clr` pulse. An error that arrives in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, factor times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high |
| cfg_factor | input | 2 | Clock factor select |
| cfg_len | input | 2 | Data length select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| rd_stb | input | 1 | Host has taken the character |
| err_clr | input | 1 | Clear all error flags |
| rx_data | output | 8 | Received character |
| rx_ready | output | 1 | Character waiting |
| parity_err | output | 1 | Sticky parity error |
| frame_err | output | 1 | Sticky framing error |
| overrun_err | output | 1 | Sticky overrun error |

## Verification
The bench builds the block with its default parameters: up to 8 data bits with a 5-bit minimum, factors 16 and 64, and a two-stage synchronizer. Under these settings every length code and all three run-time factors can be reached. Characters are sent at x1, x16 and x64. The stimulus includes a short low pulse that must be rejected at the half-bit check, good and corrupted parity of both senses, a low stop bit, and two characters sent back to back without a read, which exercises the overrun and replacement rules.

// File: rtl/rx_os_pkg.sv
// Package: shared types for the oversampling serial receiver.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package rx_os_pkg;

    // Framing state of the receiver
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // Clock factor select codes
    localparam logic [1:0] FAC_X1  = 2'b00;
    localparam logic [1:0] FAC_X16 = 2'b01;

endpackage

// File: rtl/rx_line_sync.sv
// Module: rx_line_sync
// Carries the asynchronous serial line into the clock domain through a
// chain of STAGES flops. Resets to the idle (high) level.
// Assumes STAGES >= 2.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    logic [STAGES-1:0] chain;

    // Shift the line through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
// Module: rx_bit_timer
// Down-counter that marks sampling points. A load sets the count, and the
// tick output is high in the cycle the count has reached zero.
// Assumes the controller reloads on every tick it acts upon.
module rx_bit_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;

    // Reload or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0);

endmodule

// File: rtl/rx_frame_fsm.sv
// Module: rx_frame_fsm
// Frames one character: validates the start bit, shifts data LSB first,
// accumulates and checks parity, and samples the stop bit. It pulses
// done for one cycle with the aligned character and its error bits.
// Assumes the configuration inputs are stable during a character.
module rx_frame_fsm
    import rx_os_pkg::*;
#(
    parameter int MAX_BITS   = 8,
    parameter int MIN_BITS   = 5,
    parameter int MID_FACTOR = 16,
    parameter int HI_FACTOR  = 64,
    parameter int CNT_W      = 6,
    parameter int SEL_W      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line,
    input  logic [1:0]          cfg_factor,
    input  logic [SEL_W-1:0]    cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                tick,
    output logic                load,
    output logic [CNT_W-1:0]    load_val,
    output logic                done,
    output logic [MAX_BITS-1:0] char_out,
    output logic                perr_out,
    output logic                ferr_out
);

    localparam int LEN_W = $clog2(MAX_BITS + 1);

    rx_state_e             state, state_n;
    logic [MAX_BITS-1:0]   shreg;
    logic [LEN_W-1:0]      bitcnt;
    logic                  par_acc;
    logic                  perr_q;
    logic [LEN_W-1:0]      nbits;
    logic [LEN_W-1:0]      shamt;
    logic [CNT_W-1:0]      full_val;
    logic [CNT_W-1:0]      half_val;
    logic                  is_x1;
    logic                  start_seen;

    assign nbits      = LEN_W'(MIN_BITS) + LEN_W'(cfg_len);
    assign shamt      = LEN_W'(MAX_BITS) - nbits;
    assign is_x1      = (cfg_factor == FAC_X1);
    assign start_seen = (state == ST_IDLE) && !line;

    // Decode reload values for a full and a half bit time
    always_comb begin
        case (cfg_factor)
            FAC_X1: begin
                full_val = '0;
                half_val = '0;
            end
            FAC_X16: begin
                full_val = CNT_W'(MID_FACTOR - 1);
                half_val = CNT_W'(MID_FACTOR / 2 - 1);
            end
            default: begin
                full_val = CNT_W'(HI_FACTOR - 1);
                half_val = CNT_W'(HI_FACTOR / 2 - 1);
            end
        endcase
    end

    // Next-state, timer reload and completion decode
    always_comb begin
        state_n  = state;
        load     = 1'b0;
        load_val = full_val;
        done     = 1'b0;
        case (state)
            ST_IDLE: begin
                if (!line) begin
                    load = 1'b1;
                    if (is_x1) begin
                        state_n = ST_DATA;
                    end else begin
                        state_n  = ST_START;
                        load_val = half_val;
                    end
                end
            end
            ST_START: begin
                if (tick) begin
                    if (!line) begin
                        state_n = ST_DATA;
                        load    = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    load = 1'b1;
                    if (bitcnt == nbits - 1'b1)
                        state_n = cfg_par_en ? ST_PAR : ST_STOP;
                end
            end
            ST_PAR: begin
                if (tick) begin
                    load    = 1'b1;
                    state_n = ST_STOP;
                end
            end
            ST_STOP: begin
                if (tick) begin
                    done    = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Data shift, bit count and parity accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bitcnt  <= '0;
            par_acc <= 1'b0;
            perr_q  <= 1'b0;
        end else if (start_seen) begin
            shreg   <= '0;
            bitcnt  <= '0;
            par_acc <= 1'b0;
            perr_q  <= 1'b0;
        end else if (tick && state == ST_DATA) begin
            shreg   <= {line, shreg[MAX_BITS-1:1]};
            bitcnt  <= bitcnt + 1'b1;
            par_acc <= par_acc ^ line;
        end else if (tick && state == ST_PAR) begin
            perr_q  <= line ^ par_acc ^ cfg_par_odd;
        end
    end

    assign char_out = shreg >> shamt;
    assign perr_out = perr_q & cfg_par_en;
    assign ferr_out = !line;

endmodule

// File: rtl/rx_holding.sv
// Module: rx_holding
// Receive buffer with ready flag and sticky error flags. A completed
// character always overwrites the buffer; a read clears ready.
// Assumes done is a single-cycle pulse.
module rx_holding #(
    parameter int MAX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done,
    input  logic [MAX_BITS-1:0] char_in,
    input  logic                perr_in,
    input  logic                ferr_in,
    input  logic                rd_stb,
    input  logic                err_clr,
    output logic [MAX_BITS-1:0] data_q,
    output logic                rdy_q,
    output logic                perr_q,
    output logic                ferr_q,
    output logic                ovr_q
);

    // Buffer and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            rdy_q  <= 1'b0;
        end else if (done) begin
            data_q <= char_in;
            rdy_q  <= 1'b1;
        end else if (rd_stb) begin
            rdy_q  <= 1'b0;
        end
    end

    // Sticky error flags, a new error wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (done && perr_in)              perr_q <= 1'b1;
            else if (err_clr)                 perr_q <= 1'b0;
            if (done && ferr_in)              ferr_q <= 1'b1;
            else if (err_clr)                 ferr_q <= 1'b0;
            if (done && rdy_q && !rd_stb)     ovr_q  <= 1'b1;
            else if (err_clr)                 ovr_q  <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_rx_os.sv
// Module: serial_rx_os
// Top of the oversampling asynchronous receiver: synchronizer, bit timer,
// framing controller and receive buffer.
// Assumes clk is the receive clock at 1, 16 or 64 times the bit rate.
module serial_rx_os #(
    parameter int MAX_BITS    = 8,
    parameter int MIN_BITS    = 5,
    parameter int MID_FACTOR  = 16,
    parameter int HI_FACTOR   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_line,
    input  logic [1:0]          cfg_factor,
    input  logic [1:0]          cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                rd_stb,
    input  logic                err_clr,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_ready,
    output logic                parity_err,
    output logic                frame_err,
    output logic                overrun_err
);

    localparam int CNT_W = $clog2(HI_FACTOR);

    logic                line_s;
    logic                tmr_load;
    logic [CNT_W-1:0]    tmr_val;
    logic                tmr_tick;
    logic                frm_done;
    logic [MAX_BITS-1:0] frm_char;
    logic                frm_perr;
    logic                frm_ferr;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_line),
        .d_out (line_s)
    );

    rx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tmr_tick)
    );

    rx_frame_fsm #(
        .MAX_BITS   (MAX_BITS),
        .MIN_BITS   (MIN_BITS),
        .MID_FACTOR (MID_FACTOR),
        .HI_FACTOR  (HI_FACTOR),
        .CNT_W      (CNT_W),
        .SEL_W      (2)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .line        (line_s),
        .cfg_factor  (cfg_factor),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .tick        (tmr_tick),
        .load        (tmr_load),
        .load_val    (tmr_val),
        .done        (frm_done),
        .char_out    (frm_char),
        .perr_out    (frm_perr),
        .ferr_out    (frm_ferr)
    );

    rx_holding #(.MAX_BITS(MAX_BITS)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (frm_done),
        .char_in (frm_char),
        .perr_in (frm_perr),
        .ferr_in (frm_ferr),
        .rd_stb  (rd_stb),
        .err_clr (err_clr),
        .data_q  (rx_data),
        .rdy_q   (rx_ready),
        .perr_q  (parity_err),
        .ferr_q  (frame_err),
        .ovr_q   (overrun_err)
    );

endmodule

// File: rtl/rx_os_checker.sv
// Module: rx_os_checker
// Temporal checks on the receiver's buffer and flag behaviour, attached
// to every serial_rx_os instance by the bind below.
module rx_os_checker #(
    parameter int MAX_BITS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_stb,
    input logic                err_clr,
    input logic                frm_done,
    input logic [MAX_BITS-1:0] rx_data,
    input logic                rx_ready,
    input logic                parity_err,
    input logic                frame_err,
    input logic                overrun_err
);

    // R3
    ready_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> rx_ready);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_done |=> $stable(rx_data));

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !frm_done) |=> !rx_ready);

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rx_ready && !rd_stb) |=> overrun_err);

    // R10
    clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !frm_done) |=> (!parity_err && !frame_err && !overrun_err));

    // R10
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err && !err_clr) |=> parity_err);

    // R10
    ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !err_clr) |=> frame_err);

endmodule

bind serial_rx_os rx_os_checker #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_stb      (rd_stb),
    .err_clr     (err_clr),
    .frm_done    (frm_done),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .parity_err  (parity_err),
    .frame_err   (frame_err),
    .overrun_err (overrun_err)
);

// File: tb/sim_serial_rx_os.sv
// Directed bench for serial_rx_os: one task per scenario.
module sim_serial_rx_os;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_factor = 2'b01;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rd_stb = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       parity_err;
    logic       frame_err;
    logic       overrun_err;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_rx_os u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_line     (rx_line),
        .cfg_factor  (cfg_factor),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .rd_stb      (rd_stb),
        .err_clr     (err_clr),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .parity_err  (parity_err),
        .frame_err   (frame_err),
        .overrun_err (overrun_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int factor_cycles(input logic [1:0] f);
        return (f == 2'b00) ? 1 : (f == 2'b01) ? 16 : 64;
    endfunction

    task automatic hold_bit(input logic v, input int cyc);
        rx_line = v;
        repeat (cyc) @(negedge clk);
    endtask

    // Send one character with the current configuration
    task automatic send_char(input logic [7:0] d, input bit flip_par,
                             input logic stop_lvl);
        int  f = factor_cycles(cfg_factor);
        int  nb = 5 + int'(cfg_len);
        logic p = 1'b0;
        hold_bit(1'b0, f);
        for (int i = 0; i < nb; i++) begin
            p ^= d[i];
            hold_bit(d[i], f);
        end
        if (cfg_par_en) hold_bit(p ^ cfg_par_odd ^ flip_par, f);
        hold_bit(stop_lvl, f);
        hold_bit(1'b1, f + 4);
    endtask

    task automatic pulse_read();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R3 ready after reset", rx_ready, 0);
        chk("R3 data after reset", rx_data, 0);
        chk("R10 parity flag after reset", parity_err, 0);
        chk("R10 framing flag after reset", frame_err, 0);
        chk("R10 overrun flag after reset", overrun_err, 0);
    endtask

    task automatic t_x16_basic();
        cfg_factor = 2'b01; cfg_len = 2'd3; cfg_par_en = 1'b0;
        @(negedge clk);
        send_char(8'hA5, 1'b0, 1'b1);
        chk("R1 R5 x16 8-bit data", rx_data, 8'hA5);
        chk("R3 ready raised", rx_ready, 1);
        chk("R8 no framing error", frame_err, 0);
        chk("R9 no overrun", overrun_err, 0);
        pulse_read();
        chk("R6 read clears ready", rx_ready, 0);
        chk("R6 data kept after read", rx_data, 8'hA5);
    endtask

    task automatic t_x64_parity();
        cfg_factor = 2'b10; cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        @(negedge clk);
        send_char(8'h5A, 1'b0, 1'b1);
        chk("R1 R5 x64 7-bit data", rx_data, 8'h5A);
        chk("R7 even parity good", parity_err, 0);
        pulse_read();
        cfg_par_odd = 1'b1;
        @(negedge clk);
        send_char(8'h33, 1'b0, 1'b1);
        chk("R7 odd parity good data", rx_data, 8'h33);
        chk("R7 odd parity good", parity_err, 0);
        pulse_read();
        send_char(8'h33, 1'b1, 1'b1);
        chk("R7 odd parity mismatch", parity_err, 1);
        pulse_read();
        chk("R10 parity flag survives read", parity_err, 1);
        pulse_clear();
        chk("R10 clear drops parity flag", parity_err, 0);
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    endtask

    task automatic t_x1_short();
        cfg_factor = 2'b00; cfg_len = 2'd0;
        @(negedge clk);
        send_char(8'h15, 1'b0, 1'b1);
        chk("R4 R5 x1 5-bit data, upper zero", rx_data, 8'h15);
        chk("R4 x1 ready", rx_ready, 1);
        pulse_read();
        send_char(8'h0A, 1'b0, 1'b1);
        chk("R4 x1 second pattern", rx_data, 8'h0A);
        pulse_read();
    endtask

    task automatic t_glitch();
        cfg_factor = 2'b01; cfg_len = 2'd3;
        @(negedge clk);
        hold_bit(1'b0, 3);
        hold_bit(1'b1, 200);
        chk("R2 glitch gives no character", rx_ready, 0);
        chk("R2 glitch leaves data", rx_data, 8'h0A);
        chk("R8 glitch gives no framing error", frame_err, 0);
        send_char(8'h3C, 1'b0, 1'b1);
        chk("R2 receive after glitch", rx_data, 8'h3C);
        pulse_read();
    endtask

    task automatic t_framing();
        cfg_factor = 2'b01; cfg_len = 2'd3;
        @(negedge clk);
        send_char(8'hC3, 1'b0, 1'b0);
        hold_bit(1'b1, 80);
        chk("R8 low stop sets framing flag", frame_err, 1);
        chk("R8 framed data", rx_data, 8'hC3);
        pulse_read();
        send_char(8'h81, 1'b0, 1'b1);
        chk("R10 framing flag survives good char", frame_err, 1);
        pulse_read();
        pulse_clear();
        chk("R10 clear drops framing flag", frame_err, 0);
    endtask

    task automatic t_overrun();
        cfg_factor = 2'b01; cfg_len = 2'd1;
        @(negedge clk);
        send_char(8'h11, 1'b0, 1'b1);
        chk("R9 first char no overrun", overrun_err, 0);
        send_char(8'h2E, 1'b0, 1'b1);
        chk("R9 overrun flag set", overrun_err, 1);
        chk("R9 new char replaces old", rx_data, 8'h2E);
        pulse_read();
        chk("R6 ready cleared after overrun read", rx_ready, 0);
        chk("R10 overrun flag survives read", overrun_err, 1);
        pulse_clear();
        chk("R10 clear drops overrun flag", overrun_err, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_x16_basic();
        t_x64_parity();
        t_x1_short();
        t_glitch();
        t_framing();
        t_overrun();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule